// File: doc/BRIEF.md
# Dual-Role Full-Duplex SPI Port with Word FIFOs

This block is a serial peripheral port that runs either as the bus master or as a bus slave. A mode input selects the role. In the master role the port generates the serial clock from a programmable divider and drives the active-low select line. In the slave role it samples an external clock, select and data through a two-flop synchronizer. Every serial clock shifts one bit out and captures one bit in at the same time. Words are 8 bits, most significant bit first. Data changes on the falling clock edge and is sampled on the rising edge, and the clock idles low.

A transmit FIFO and a receive FIFO sit between the host and the shifter, so several words can pass without host action between them. The host side is a plain push/pop interface with show-ahead read data. Two request outputs let a DMA engine keep each FIFO serviced. Sticky flags report a transmit underrun in the slave role and a receive overflow. Each pad has an output, an input and an output-enable, so the pad ring can tri-state it.

Top module: `spi_dual_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, all four output enables are low, `sclk_o` is low and `cs_n_o` is high. In that window both FIFOs are empty and both sticky flags are clear.
- R2: In the master role (`is_master`=1), a non-empty transmit FIFO starts a word. `cs_n_o` goes low, and exactly 8 rising edges of `sclk_o` follow, each clock half lasting `clk_div`+1 cycles. `cs_n_o` returns high together with the 8th falling edge. `sclk_o` is low whenever `cs_n_o` is high.
- R3: In the master role, the word popped from the transmit FIFO appears on `mosi_o` MSB first and changes only on falling edges. The 8 bits sampled from `miso_i` on the rising edges are pushed into the receive FIFO as one word, the first bit becoming bit 7.
- R4: In the master role `sclk_oe`, `cs_n_oe` and `mosi_oe` are high and `miso_oe` is low. In the slave role those three are low, and `miso_oe` is high only while the synchronized `cs_n_i` is low.
- R5: In the slave role, a falling `cs_n_i` loads the next transmit word, which is shifted out on `miso_o` MSB first. The 8 bits sampled from `mosi_i` on rising `sclk_i` edges are pushed into the receive FIFO.
- R6: In the slave role, with `cs_n_i` held low, the next word's MSB is driven right after the falling edge that follows the previous word's last bit. The next rising edge is its first bit, with no idle clock.
- R7: If a slave word starts with an empty transmit FIFO, it is shifted out as all zeros. `underrun_flag` sets at its first rising edge and stays set until reset. A word loaded but never clocked does not set it.
- R8: A received word that finds the receive FIFO full is dropped and the stored words are kept. `overflow_flag` sets and stays set until reset.
- R9: `dma_wr_req` is high while the transmit FIFO has at least one free entry. `dma_rd_req` is high while the receive FIFO holds at least one word.
- R10: A push into a full transmit FIFO is ignored, and a pop of an empty receive FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| clk_div | input | DIV_W | Serial clock half period minus one, in system cycles |
| tx_push | input | 1 | Write one word into the transmit FIFO |
| tx_data | input | WORD_W | Word to write |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Remove the head word of the receive FIFO |
| rx_data | output | WORD_W | Head word of the receive FIFO (show-ahead) |
| rx_empty | output | 1 | Receive FIFO empty |
| dma_wr_req | output | 1 | Transmit FIFO can accept a word |
| dma_rd_req | output | 1 | Receive FIFO holds a word |
| underrun_flag | output | 1 | Sticky: a slave word was sent with no data |
| overflow_flag | output | 1 | Sticky: a received word was dropped |
| sclk_i | input | 1 | Serial clock from pad |
| sclk_o | output | 1 | Serial clock to pad |
| sclk_oe | output | 1 | Serial clock pad drive enable |
| cs_n_i | input | 1 | Select from pad, active low |
| cs_n_o | output | 1 | Select to pad, active low |
| cs_n_oe | output | 1 | Select pad drive enable |
| mosi_i | input | 1 | Master-to-slave data from pad |
| mosi_o | output | 1 | Master-to-slave data to pad |
| mosi_oe | output | 1 | Master-to-slave pad drive enable |
| miso_i | input | 1 | Slave-to-master data from pad |
| miso_o | output | 1 | Slave-to-master data to pad |
| miso_oe | output | 1 | Slave-to-master pad drive enable |

## Verification
The assertions check on every cycle the reset release of the pads, the enable pattern that follows the role input, the rule that the master clock stays low while select is high, and that both error flags stay set. Bit order, word contents in both directions, and the half-period length can only be shown by the bench scenarios, which model the far end of the link. The same holds for the seamless hand-over between back-to-back slave words, the zero fill on underrun and the word dropped on overflow.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_RUN  = 2'd1,
    MS_GAP  = 2'd2
  } mseq_state_t;

  // pad sample order inside the synchronizer vector
  localparam int unsigned PAD_SCLK = 2;
  localparam int unsigned PAD_CSN  = 1;
  localparam int unsigned PAD_MOSI = 0;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  // storage without reset so a RAM primitive can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned         N       = 3,
  parameter int unsigned         STAGES  = 2,
  parameter logic [N-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= RST_VAL;
      else     stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mseq.sv
module spi_mseq
  import spi_dual_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             have_data,
  output logic             load_req,
  output logic             sample_p,
  output logic             shift_p,
  output logic             sclk,
  output logic             cs_n
);
  localparam int unsigned HALVES = 2 * W;
  localparam int unsigned HW     = $clog2(HALVES);

  mseq_state_t      st;
  logic [DIV_W-1:0] div;
  logic [HW-1:0]    hcnt;
  logic             tick, last_half;

  assign tick      = (div == clk_div);
  assign last_half = (hcnt == HW'(HALVES - 1));
  assign load_req  = en && (st == MS_IDLE) && have_data;
  assign sample_p  = (st == MS_RUN) && tick && !sclk;
  assign shift_p   = (st == MS_RUN) && tick && sclk && !last_half;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st   <= MS_IDLE;
      div  <= '0;
      hcnt <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
    end else begin
      unique case (st)
        MS_IDLE: begin
          if (have_data) begin
            st   <= MS_RUN;
            cs_n <= 1'b0;
            div  <= '0;
            hcnt <= '0;
          end
        end
        MS_RUN: begin
          if (tick) begin
            div  <= '0;
            sclk <= ~sclk;
            hcnt <= hcnt + 1'b1;
            if (last_half) begin
              st   <= MS_GAP;
              cs_n <= 1'b1;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        MS_GAP: begin
          if (tick) begin
            div <= '0;
            st  <= MS_IDLE;
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  input  logic         sample,
  input  logic         sample_bit,
  output logic         out_bit,
  output logic         last_bit,
  output logic         word_valid,
  output logic [W-1:0] word_data
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  tx_sh, rx_sh;
  logic [CW-1:0] cnt;

  assign out_bit  = tx_sh[W-1];
  assign last_bit = (cnt == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh      <= '0;
      rx_sh      <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (sample) begin
        rx_sh <= {rx_sh[W-2:0], sample_bit};
        if (last_bit) begin
          cnt        <= '0;
          word_valid <= 1'b1;
          word_data  <= {rx_sh[W-2:0], sample_bit};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (load) begin
        tx_sh <= load_data;
        cnt   <= '0;
      end else if (shift) begin
        tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
  import spi_dual_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned TX_DEPTH    = 4,
  parameter int unsigned RX_DEPTH    = 4,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              tx_push,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              dma_wr_req,
  output logic              dma_rd_req,
  output logic              underrun_flag,
  output logic              overflow_flag,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              cs_n_i,
  output logic              cs_n_o,
  output logic              cs_n_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);
  localparam logic [2:0] PAD_IDLE = 3'b010;

  // transmit side
  logic              tx_empty, tx_pop;
  logic [WORD_W-1:0] tx_head;
  // receive side
  logic              rx_full, rx_push;
  logic [WORD_W-1:0] rx_word;
  // shared shifter controls
  logic              sh_load, sh_shift, sh_sample, sh_bit, sh_out, sh_last;
  logic [WORD_W-1:0] sh_load_data;
  // master sequencer
  logic              m_load, m_sample, m_shift;
  // slave side
  logic [2:0]        pad_s;
  logic              s_sclk, s_cs_n, s_mosi, p_sclk, p_cs_n;
  logic              sl_en, sl_active, sl_start, sl_rise, sl_fall;
  logic              sl_load, sl_shift, pend, starved;

  spi_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txf (
    .clk(clk), .rst(rst), .push(tx_push), .din(tx_data), .pop(tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spi_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_data), .empty(rx_empty), .full(rx_full)
  );

  spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(PAD_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d({sclk_i, cs_n_i, mosi_i}), .q(pad_s)
  );

  spi_mseq #(.W(WORD_W), .DIV_W(DIV_W)) u_mseq (
    .clk(clk), .rst(rst), .en(is_master), .clk_div(clk_div),
    .have_data(!tx_empty), .load_req(m_load), .sample_p(m_sample),
    .shift_p(m_shift), .sclk(sclk_o), .cs_n(cs_n_o)
  );

  // slave edge detection on synchronized pads
  assign s_sclk    = pad_s[PAD_SCLK];
  assign s_cs_n    = pad_s[PAD_CSN];
  assign s_mosi    = pad_s[PAD_MOSI];
  assign sl_en     = !is_master;
  assign sl_active = sl_en && !s_cs_n;
  assign sl_start  = sl_active && p_cs_n;
  assign sl_rise   = sl_active && !sl_start && !p_sclk && s_sclk;
  assign sl_fall   = sl_active && !sl_start && p_sclk && !s_sclk;
  assign sl_load   = sl_start || (sl_fall && pend);
  assign sl_shift  = sl_fall && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_sclk <= 1'b0;
      p_cs_n <= 1'b1;
      pend   <= 1'b0;
    end else begin
      p_sclk <= s_sclk;
      p_cs_n <= s_cs_n;
      if (!sl_active || sl_load) pend <= 1'b0;
      else if (sl_rise && sh_last) pend <= 1'b1;
    end
  end

  // role mux into the single shifter
  assign sh_load      = is_master ? m_load   : sl_load;
  assign sh_shift     = is_master ? m_shift  : sl_shift;
  assign sh_sample    = is_master ? m_sample : sl_rise;
  assign sh_bit       = is_master ? miso_i   : s_mosi;
  assign tx_pop       = sh_load && !tx_empty;
  assign sh_load_data = tx_empty ? '0 : tx_head;

  spi_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_data(sh_load_data),
    .shift(sh_shift), .sample(sh_sample), .sample_bit(sh_bit),
    .out_bit(sh_out), .last_bit(sh_last), .word_valid(rx_push),
    .word_data(rx_word)
  );

  assign mosi_o     = sh_out;
  assign miso_o     = sh_out;
  assign dma_wr_req = !tx_full;
  assign dma_rd_req = !rx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      starved       <= 1'b0;
      underrun_flag <= 1'b0;
      overflow_flag <= 1'b0;
      sclk_oe       <= 1'b0;
      cs_n_oe       <= 1'b0;
      mosi_oe       <= 1'b0;
      miso_oe       <= 1'b0;
    end else begin
      if (sh_load) starved <= tx_empty && !is_master;
      if (sl_rise && starved) underrun_flag <= 1'b1;
      if (rx_push && rx_full) overflow_flag <= 1'b1;
      sclk_oe <= is_master;
      cs_n_oe <= is_master;
      mosi_oe <= is_master;
      miso_oe <= sl_active;
    end
  end
endmodule

// File: rtl/spi_dual_chk.sv
module spi_dual_chk (
  input logic clk,
  input logic rst,
  input logic is_master,
  input logic sclk_o,
  input logic cs_n_o,
  input logic sclk_oe,
  input logic cs_n_oe,
  input logic mosi_oe,
  input logic miso_oe,
  input logic underrun_flag,
  input logic overflow_flag
);
  assert_pads_released_R1: assert property (@(posedge clk)
    rst |=> (!sclk_oe && !cs_n_oe && !mosi_oe && !miso_oe && !sclk_o && cs_n_o));

  assert_clk_low_when_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  assert_master_miso_released_R4: assert property (@(posedge clk) disable iff (rst)
    is_master |=> !miso_oe);

  assert_slave_outputs_released_R4: assert property (@(posedge clk) disable iff (rst)
    !is_master |=> (!sclk_oe && !cs_n_oe && !mosi_oe));

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    underrun_flag |=> underrun_flag);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflow_flag |=> overflow_flag);
endmodule

bind spi_dual_ctrl spi_dual_chk u_chk (.*);

// File: tb/spi_dual_ctrl_tb.sv
`timescale 1ns/1ps
module spi_dual_ctrl_tb;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       is_master = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic       tx_push = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rx_pop = 1'b0;
  logic       sclk_i = 1'b0, cs_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
  logic       tx_full, rx_empty, dma_wr_req, dma_rd_req, underrun_flag, overflow_flag;
  logic [7:0] rx_data;
  logic       sclk_o, sclk_oe, cs_n_o, cs_n_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  spi_dual_ctrl u_dut (
    .clk(clk), .rst(rst), .is_master(is_master), .clk_div(clk_div),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req),
    .underrun_flag(underrun_flag), .overflow_flag(overflow_flag),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .cs_n_i(cs_n_i), .cs_n_o(cs_n_o), .cs_n_oe(cs_n_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external slave device used in master-role tests
  logic       model_on = 1'b0;
  logic [7:0] ext_reply [8];
  logic [7:0] ext_got [8];
  logic [7:0] ext_sh, ext_cap;
  int         ext_idx = 0, ext_bits = 0, ext_bad_len = 0;
  time        last_rise = 0, half_meas = 0;
  logic       half_done = 1'b0;

  always @(negedge cs_n_o) if (model_on) begin
    ext_sh   = ext_reply[ext_idx];
    miso_i   = ext_sh[7];
    ext_bits = 0;
  end
  always @(posedge sclk_o) if (model_on && !cs_n_o) begin
    ext_cap   = {ext_cap[6:0], mosi_o};
    ext_bits++;
    last_rise = $time;
    if (ext_bits == 8) begin
      ext_got[ext_idx] = ext_cap;
      ext_idx++;
    end
  end
  always @(negedge sclk_o) if (model_on) begin
    if (!half_done) begin
      half_meas = $time - last_rise;
      half_done = 1'b1;
    end
    ext_sh = {ext_sh[6:0], 1'b0};
    miso_i = ext_sh[7];
  end
  always @(posedge cs_n_o) if (model_on && ext_bits != 8) ext_bad_len++;

  // bench-side master used in slave-role tests
  logic [7:0] bm_tx [8];
  logic [7:0] bm_rx [8];
  int         oe_bad = 0;

  task automatic push_word(input logic [7:0] v);
    @(negedge clk); tx_push = 1'b1; tx_data = v;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {24'h0, rx_data}, {24'h0, exp});
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic slave_xfer(input int n);
    @(negedge clk); cs_n_i = 1'b0; mosi_i = bm_tx[0][7];
    for (int k = 0; k < n; k++) begin
      logic [7:0] cap;
      cap = 8'h00;
      for (int b = 7; b >= 0; b--) begin
        repeat (HP) @(negedge clk);
        sclk_i = 1'b1;
        cap = {cap[6:0], miso_o};
        if (miso_oe !== 1'b1 || sclk_oe !== 1'b0 || cs_n_oe !== 1'b0 || mosi_oe !== 1'b0) oe_bad++;
        repeat (HP) @(negedge clk);
        sclk_i = 1'b0;
        if (b > 0) mosi_i = bm_tx[k][b-1];
        else if (k + 1 < n) mosi_i = bm_tx[k+1][7];
      end
      bm_rx[k] = cap;
    end
    repeat (HP) @(negedge clk); cs_n_i = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; is_master = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 oe during reset", {28'h0, sclk_oe, cs_n_oe, mosi_oe, miso_oe}, 32'h0);
    check("R1 sclk/cs idle", {30'h0, sclk_o, cs_n_o}, 32'h1);
    check("R1 fifos empty", {30'h0, rx_empty, tx_full}, 32'h2);
    check("R1 flags clear", {30'h0, underrun_flag, overflow_flag}, 32'h0);
    check("R9 reset dma", {30'h0, dma_wr_req, dma_rd_req}, 32'h2);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after release (slave)", {28'h0, sclk_oe, cs_n_oe, mosi_oe, miso_oe}, 32'h0);
  endtask

  task automatic t_master();
    ext_reply[0] = 8'h5A; ext_reply[1] = 8'hC3;
    ext_idx = 0; ext_bad_len = 0; half_done = 1'b0;
    model_on = 1'b1;
    clk_div = 8'd1;
    @(negedge clk); is_master = 1'b1;
    push_word(8'hA5);
    push_word(8'h3C);
    check("R4 master oe", {28'h0, sclk_oe, cs_n_oe, mosi_oe, miso_oe}, 32'hE);
    for (int i = 0; i < 2000 && !(ext_idx == 2 && cs_n_o); i++) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R2 two words framed", ext_idx, 2);
    check("R2 eight rising edges per select", ext_bad_len, 0);
    check("R2 half period", 32'(half_meas), 32'd40);
    check("R3 mosi word 0", {24'h0, ext_got[0]}, 32'hA5);
    check("R3 mosi word 1", {24'h0, ext_got[1]}, 32'h3C);
    pop_check("R3 rx word 0", 8'h5A);
    pop_check("R3 rx word 1", 8'hC3);
    check("R9 rd req drops when empty", {31'h0, dma_rd_req}, 32'h0);
    model_on = 1'b0;
    @(negedge clk); is_master = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_slave();
    push_word(8'h96);
    push_word(8'h0F);
    bm_tx[0] = 8'h11; bm_tx[1] = 8'hEE;
    oe_bad = 0;
    slave_xfer(2);
    check("R4 slave oe while selected", oe_bad, 0);
    check("R4 miso released after deselect", {31'h0, miso_oe}, 32'h0);
    check("R5 miso word 0", {24'h0, bm_rx[0]}, 32'h96);
    check("R6 back-to-back miso word 1", {24'h0, bm_rx[1]}, 32'h0F);
    check("R7 no underrun on unclocked load", {31'h0, underrun_flag}, 32'h0);
    pop_check("R5 rx word 0", 8'h11);
    pop_check("R6 rx word 1", 8'hEE);
  endtask

  task automatic t_underrun();
    bm_tx[0] = 8'h77;
    slave_xfer(1);
    check("R7 zero fill", {24'h0, bm_rx[0]}, 32'h0);
    check("R7 underrun set", {31'h0, underrun_flag}, 32'h1);
    pop_check("R5 rx during underrun", 8'h77);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 5; i++) bm_tx[i] = 8'(i + 1);
    slave_xfer(5);
    check("R8 overflow set", {31'h0, overflow_flag}, 32'h1);
    check("R9 rd req while filled", {31'h0, dma_rd_req}, 32'h1);
    for (int i = 0; i < 4; i++) pop_check("R8 stored word kept", 8'(i + 1));
    check("R8 dropped word absent", {31'h0, rx_empty}, 32'h1);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    check("R10 pop of empty ignored", {30'h0, rx_empty, dma_rd_req}, 32'h2);
  endtask

  task automatic t_full();
    push_word(8'h10); push_word(8'h20); push_word(8'h30);
    check("R9 wr req with space", {31'h0, dma_wr_req}, 32'h1);
    push_word(8'h40);
    check("R9 wr req when full", {30'h0, dma_wr_req, tx_full}, 32'h1);
    push_word(8'hEE);
    for (int i = 0; i < 4; i++) bm_tx[i] = 8'h00;
    slave_xfer(4);
    check("R10 word 0", {24'h0, bm_rx[0]}, 32'h10);
    check("R10 word 3 not overwritten", {24'h0, bm_rx[3]}, 32'h40);
    check("R10 tx drained", {31'h0, dma_wr_req}, 32'h1);
    check("R7 no underrun after drain", {31'h0, underrun_flag}, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_master();
        t_slave();
        t_underrun();
        do_reset();
        t_overflow();
        do_reset();
        t_full();
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule